// File: doc/BRIEF.md
# Packet Modem Host Register Interface

This block is the 8-bit parallel host port of a packet modem. A host controller reaches it through two address lines, an active-low chip select and active-low read and write strobes. Each address has a different target for writes than for reads: writes reach a command, a control and a mode register, while reads return status and a signal-quality byte from the modem. The first address is a single window onto an 18-byte data buffer. The buffer steps to its next location after every accepted access.

Use of the buffer is restricted. An access only takes effect while the buffer-free flag is set. Writes are allowed in transmit mode, or in receive mode when a sync-pattern load enable is set. Reads are allowed only in receive mode. A command write splits the byte into a task code, a level bit and a bit-clock acquisition request. It sends one-cycle pulses to the modem datapath and rewinds the buffer pointer. The datapath reaches the same buffer through a side port. It reports back with `buf_free_i` when the buffer is free again and with `task_done_i` when a task is complete. Host strobes are taken as already synchronous to `clk_i`.

Top module: `modem_hif`

## Requirements
- R1: Reads decode the address as follows: 01 returns the status byte {buffer-free flag in bit 7, `stat_i` in bits 6..0}, 10 returns `dq_i`, and 11 returns 8'h00.
- R2: `data_oe_o` is high only while chip select and the read strobe are both low.
- R3: A write at address 01 is the command register, 10 is the control register (shown on `ctrl_o`) and 11 is the mode register (shown on `mode_o`). Mode bit 0 selects transmit, bit 1 selects power-save and bit 2 enables sync-pattern writes in receive mode. All three registers are 0 after reset.
- R4: Accepted host accesses at address 00 go to buffer locations 0, 1, 2 and so on, in order. The datapath side port sees the same storage.
- R5: After each accepted buffer access the pointer advances by one, and it stays at 17 once it gets there. All further writes land in location 17.
- R6: Every accepted command write puts the buffer pointer back at 0.
- R7: While the buffer-free flag is 0, a buffer write stores nothing and a buffer read returns 8'h00. In both cases the pointer does not move.
- R8: Buffer writes are accepted in transmit mode, and in receive mode only when mode bit 2 is set. Buffer reads are accepted only in receive mode. A rejected access leaves storage and the pointer unchanged, and a rejected read returns 8'h00.
- R9: A command byte is laid out as acquire in bit 7, level in bit 6, reserved bits 5..3 and task in bits 2..0. If the reserved bits are 0, `task_stb_o` pulses for one cycle with the task on `task_o`. If any reserved bit is 1, the whole byte is ignored: no pulse, no pointer reset, no level change.
- R10: `aqbc_stb_o` pulses together with the task pulse when bit 7 is 1, the mode is receive and the task is not 7 (reset). `aqlev_o` holds bit 6 of the last accepted command.
- R11: The buffer-free flag is 1 after reset. An accepted command with a non-zero task clears it, and a `buf_free_i` pulse sets it.
- R12: A non-zero task makes the block busy until `task_done_i`. `idle_o` is high when the block is neither busy nor in power-save. `bias_hold_o` is high when idle in transmit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register address |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| data_oe_o | output | 1 | Read data bus drive enable |
| stat_i | input | 7 | Modem status bits for the status byte |
| dq_i | input | 8 | Received signal quality value |
| ctrl_o | output | 8 | Control register contents |
| mode_o | output | 8 | Mode register contents |
| task_stb_o | output | 1 | One-cycle task start pulse |
| task_o | output | 3 | Task code of the last accepted command |
| aqbc_stb_o | output | 1 | One-cycle bit-clock acquisition request |
| aqlev_o | output | 1 | Level bit of the last accepted command |
| buf_free_i | input | 1 | Datapath hands the buffer back to the host |
| task_done_i | input | 1 | Datapath has finished the current task |
| idle_o | output | 1 | No task pending and not in power-save |
| bias_hold_o | output | 1 | Hold transmit filter input at bias level |
| dp_we_i | input | 1 | Datapath buffer write enable |
| dp_addr_i | input | 5 | Datapath buffer location |
| dp_wdata_i | input | 8 | Datapath buffer write data |
| dp_rdata_o | output | 8 | Datapath buffer read data |

## Verification
The bench builds the block with its default parameters: an 8-bit bus and an 18-entry buffer. With these values a run of twenty buffer writes reaches the pointer's saturation point, and the last three of those writes fall on location 17. Because the byte width is 8, the command field positions, the status bit and the 8'h00 return for rejected reads all sit at the exact bits the requirements state.

// File: rtl/modem_hif_pkg.sv
package modem_hif_pkg;

    typedef enum logic [1:0] {
        SEL_BUF  = 2'b00,
        SEL_CMD  = 2'b01,
        SEL_CTL  = 2'b10,
        SEL_MODE = 2'b11
    } hif_sel_e;

    localparam int TASK_W = 3;
    localparam logic [TASK_W-1:0] TASK_NONE  = 3'd0;
    localparam logic [TASK_W-1:0] TASK_RESET = 3'd7;

    localparam int CMD_ACQ_BIT = 7;
    localparam int CMD_LEV_BIT = 6;
    localparam int CMD_RSV_HI  = 5;
    localparam int CMD_RSV_LO  = 3;

    localparam int MODE_TX_BIT    = 0;
    localparam int MODE_PSAVE_BIT = 1;
    localparam int MODE_SYNCW_BIT = 2;

endpackage

// File: rtl/hif_strobe.sv
module hif_strobe (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic cs_n_i,
    input  logic rd_n_i,
    input  logic wr_n_i,
    output logic wr_evt_o,
    output logic rd_act_o,
    output logic rd_start_o,
    output logic rd_end_o
);
    typedef struct packed {
        logic wr_prev;
        logic rd_prev;
    } strb_t;

    strb_t st_d, st_q;
    logic  wr_act;

    always_comb begin
        wr_act         = !cs_n_i && !wr_n_i;
        rd_act_o       = !cs_n_i && !rd_n_i;
        st_d.wr_prev   = wr_act;
        st_d.rd_prev   = rd_act_o;
        wr_evt_o       = wr_act && !st_q.wr_prev;
        rd_start_o     = rd_act_o && !st_q.rd_prev;
        rd_end_o       = !rd_act_o && st_q.rd_prev;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end
endmodule

// File: rtl/hif_buffer.sv
module hif_buffer #(
    parameter int DW    = 8,
    parameter int DEPTH = 18,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          host_we_i,
    input  logic [DW-1:0] host_wdata_i,
    input  logic [AW-1:0] ptr_i,
    input  logic          dp_we_i,
    input  logic [AW-1:0] dp_addr_i,
    input  logic [DW-1:0] dp_wdata_i,
    output logic [DW-1:0] host_rdata_o,
    output logic [DW-1:0] dp_rdata_o
);
    localparam int MEM_W = DEPTH * DW;

    logic [MEM_W-1:0] mem_d, mem_q;

    // Host access has priority over the datapath on the same location.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign mem_d[g*DW +: DW] =
            (host_we_i && (ptr_i == AW'(g)))   ? host_wdata_i :
            (dp_we_i   && (dp_addr_i == AW'(g))) ? dp_wdata_i   :
                                                   mem_q[g*DW +: DW];
    end

    always_comb begin
        host_rdata_o = '0;
        dp_rdata_o   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ptr_i == AW'(i))     host_rdata_o = mem_q[i*DW +: DW];
            if (dp_addr_i == AW'(i)) dp_rdata_o   = mem_q[i*DW +: DW];
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) mem_q <= '0;
        else          mem_q <= mem_d;
    end
endmodule

// File: rtl/hif_cmd.sv
module hif_cmd
    import modem_hif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              cmd_wr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic              tx_mode_i,
    output logic              take_o,
    output logic              task_stb_o,
    output logic [TASK_W-1:0] task_o,
    output logic              aqbc_stb_o,
    output logic              aqlev_o
);
    typedef struct packed {
        logic              task_stb;
        logic [TASK_W-1:0] code;
        logic              aqbc_stb;
        logic              aqlev;
    } cmd_t;

    cmd_t              st_d, st_q;
    logic [TASK_W-1:0] new_code;

    always_comb begin
        new_code = wdata_i[TASK_W-1:0];
        take_o   = cmd_wr_i && (wdata_i[CMD_RSV_HI:CMD_RSV_LO] == '0);

        st_d          = st_q;
        st_d.task_stb = 1'b0;
        st_d.aqbc_stb = 1'b0;
        if (take_o) begin
            st_d.task_stb = 1'b1;
            st_d.code     = new_code;
            st_d.aqlev    = wdata_i[CMD_LEV_BIT];
            st_d.aqbc_stb = wdata_i[CMD_ACQ_BIT] && !tx_mode_i
                            && (new_code != TASK_RESET);
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign task_stb_o = st_q.task_stb;
    assign task_o     = st_q.code;
    assign aqbc_stb_o = st_q.aqbc_stb;
    assign aqlev_o    = st_q.aqlev;
endmodule

// File: rtl/modem_hif.sv
module modem_hif
    import modem_hif_pkg::*;
#(
    parameter  int DW    = 8,
    parameter  int DEPTH = 18,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [1:0]        addr_i,
    input  logic [DW-1:0]     data_i,
    output logic [DW-1:0]     data_o,
    output logic              data_oe_o,
    input  logic [DW-2:0]     stat_i,
    input  logic [DW-1:0]     dq_i,
    output logic [DW-1:0]     ctrl_o,
    output logic [DW-1:0]     mode_o,
    output logic              task_stb_o,
    output logic [TASK_W-1:0] task_o,
    output logic              aqbc_stb_o,
    output logic              aqlev_o,
    input  logic              buf_free_i,
    input  logic              task_done_i,
    output logic              idle_o,
    output logic              bias_hold_o,
    input  logic              dp_we_i,
    input  logic [AW-1:0]     dp_addr_i,
    input  logic [DW-1:0]     dp_wdata_i,
    output logic [DW-1:0]     dp_rdata_o
);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] mode;
        logic [AW-1:0] ptr;
        logic          bfree;
        logic          busy;
        logic          rd_ok;
    } hif_t;

    hif_t     st_d, st_q;
    hif_sel_e sel;

    logic          wr_evt, rd_act, rd_start, rd_end;
    logic          cmd_wr, cmd_take;
    logic          tx_mode, buf_wr_ok, buf_rd_ok;
    logic          host_we, buf_step;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] ptr_w;
    logic          bfree_w;

    hif_strobe u_strobe (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .cs_n_i     (cs_n_i),
        .rd_n_i     (rd_n_i),
        .wr_n_i     (wr_n_i),
        .wr_evt_o   (wr_evt),
        .rd_act_o   (rd_act),
        .rd_start_o (rd_start),
        .rd_end_o   (rd_end)
    );

    hif_cmd #(.DW(DW)) u_cmd (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .cmd_wr_i   (cmd_wr),
        .wdata_i    (data_i),
        .tx_mode_i  (tx_mode),
        .take_o     (cmd_take),
        .task_stb_o (task_stb_o),
        .task_o     (task_o),
        .aqbc_stb_o (aqbc_stb_o),
        .aqlev_o    (aqlev_o)
    );

    hif_buffer #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .host_we_i    (host_we),
        .host_wdata_i (data_i),
        .ptr_i        (st_q.ptr),
        .dp_we_i      (dp_we_i),
        .dp_addr_i    (dp_addr_i),
        .dp_wdata_i   (dp_wdata_i),
        .host_rdata_o (host_rdata),
        .dp_rdata_o   (dp_rdata_o)
    );

    // Access decode and next-state
    always_comb begin
        sel       = hif_sel_e'(addr_i);
        tx_mode   = st_q.mode[MODE_TX_BIT];
        buf_wr_ok = st_q.bfree && (tx_mode || st_q.mode[MODE_SYNCW_BIT]);
        buf_rd_ok = st_q.bfree && !tx_mode;
        cmd_wr    = wr_evt && (sel == SEL_CMD);
        host_we   = wr_evt && (sel == SEL_BUF) && buf_wr_ok;
        buf_step  = host_we || (rd_end && st_q.rd_ok);

        st_d = st_q;

        if (wr_evt && (sel == SEL_CTL))  st_d.ctrl = data_i;
        if (wr_evt && (sel == SEL_MODE)) st_d.mode = data_i;

        if (rd_start) st_d.rd_ok = buf_rd_ok && (sel == SEL_BUF);
        else if (rd_end) st_d.rd_ok = 1'b0;

        if (cmd_take) begin
            st_d.ptr = '0;
        end else if (buf_step && (st_q.ptr != PTR_LAST)) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end

        if (cmd_take && (data_i[TASK_W-1:0] != TASK_NONE)) begin
            st_d.bfree = 1'b0;
            st_d.busy  = 1'b1;
        end else begin
            if (buf_free_i)  st_d.bfree = 1'b1;
            if (task_done_i) st_d.busy  = 1'b0;
        end
    end

    // Host read mux
    always_comb begin
        data_oe_o = rd_act;
        unique case (sel)
            SEL_BUF: data_o = buf_rd_ok ? host_rdata : '0;
            SEL_CMD: data_o = {st_q.bfree, stat_i};
            SEL_CTL: data_o = dq_i;
            default: data_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q       <= '0;
            st_q.bfree <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o      = st_q.ctrl;
    assign mode_o      = st_q.mode;
    assign idle_o      = !st_q.busy && !st_q.mode[MODE_PSAVE_BIT];
    assign bias_hold_o = idle_o && st_q.mode[MODE_TX_BIT];
    assign ptr_w       = st_q.ptr;
    assign bfree_w     = st_q.bfree;
endmodule

// File: rtl/modem_hif_chk.sv
module modem_hif_chk
    import modem_hif_pkg::*;
#(
    parameter  int DW    = 8,
    parameter  int DEPTH = 18,
    localparam int AW    = $clog2(DEPTH)
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              cs_n_i,
    input logic              rd_n_i,
    input logic              data_oe_i,
    input logic              task_stb_i,
    input logic [TASK_W-1:0] task_i,
    input logic              aqbc_stb_i,
    input logic [DW-1:0]     mode_i,
    input logic              idle_i,
    input logic [AW-1:0]     ptr_i,
    input logic              bfree_i
);
    AST_OE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        data_oe_i |-> (!cs_n_i && !rd_n_i)); // R2

    AST_TASK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        task_stb_i |=> !task_stb_i); // R9

    AST_AQBC_WITH_TASK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        aqbc_stb_i |-> (task_stb_i && task_i != TASK_RESET)); // R10

    AST_AQBC_RX_ONLY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        aqbc_stb_i |-> !mode_i[MODE_TX_BIT]); // R10

    AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ptr_i <= AW'(DEPTH - 1)); // R5

    AST_PTR_ON_CMD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        task_stb_i |-> (ptr_i == '0)); // R6

    AST_BFREE_ON_TASK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (task_stb_i && task_i != TASK_NONE) |-> !bfree_i); // R11

    AST_BUSY_ON_TASK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (task_stb_i && task_i != TASK_NONE) |-> !idle_i); // R12
endmodule

bind modem_hif modem_hif_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .cs_n_i     (cs_n_i),
    .rd_n_i     (rd_n_i),
    .data_oe_i  (data_oe_o),
    .task_stb_i (task_stb_o),
    .task_i     (task_o),
    .aqbc_stb_i (aqbc_stb_o),
    .mode_i     (mode_o),
    .idle_i     (idle_o),
    .ptr_i      (ptr_w),
    .bfree_i    (bfree_w)
);

// File: tb/modem_hif_tb.sv
module modem_hif_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       oe;
    logic [6:0] stat = 7'h15;
    logic [7:0] dq = 8'h5A;
    logic [7:0] ctrl, mode;
    logic       task_stb, aqbc_stb, aqlev, idle, bias;
    logic [2:0] task_code;
    logic       buf_free = 1'b0, task_done = 1'b0;
    logic       dp_we = 1'b0;
    logic [4:0] dp_addr = 5'd0;
    logic [7:0] dp_wdata = 8'h00;
    logic [7:0] dp_rdata;

    int total = 0;
    int bad = 0;
    int n_task = 0;
    int n_aqbc = 0;
    logic [2:0] last_task = 3'd0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    modem_hif u_dut (
        .clk_i(clk), .rst_n_i(rst_n), .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
        .addr_i(addr), .data_i(wdata), .data_o(rdata), .data_oe_o(oe),
        .stat_i(stat), .dq_i(dq), .ctrl_o(ctrl), .mode_o(mode),
        .task_stb_o(task_stb), .task_o(task_code), .aqbc_stb_o(aqbc_stb), .aqlev_o(aqlev),
        .buf_free_i(buf_free), .task_done_i(task_done), .idle_o(idle), .bias_hold_o(bias),
        .dp_we_i(dp_we), .dp_addr_i(dp_addr), .dp_wdata_i(dp_wdata), .dp_rdata_o(dp_rdata)
    );

    always @(negedge clk) begin
        if (task_stb) begin
            n_task++;
            last_task = task_code;
        end
        if (aqbc_stb) n_aqbc++;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] d, output logic e);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        @(negedge clk);
        d = rdata; e = oe;
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic peek(input int loc, output logic [7:0] d);
        dp_addr = 5'(loc);
        #1;
        d = dp_rdata;
    endtask

    task automatic release_buf();
        @(negedge clk); buf_free = 1'b1; task_done = 1'b1;
        @(negedge clk); buf_free = 1'b0; task_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic e;
        check("R2 oe idle", {7'd0, oe}, 8'h00);
        check("R3 ctrl reset", ctrl, 8'h00);
        check("R3 mode reset", mode, 8'h00);
        check("R12 idle reset", {7'd0, idle}, 8'h01);
        check("R12 bias rx", {7'd0, bias}, 8'h00);
        host_rd(2'b01, d, e);
        check("R11 R1 status reset", d, 8'h95);
    endtask

    task automatic t_map();
        logic [7:0] d; logic e;
        host_rd(2'b10, d, e);
        check("R1 dq read", d, 8'h5A);
        check("R2 oe during read", {7'd0, e}, 8'h01);
        host_rd(2'b11, d, e);
        check("R1 addr11 read", d, 8'h00);
        check("R2 oe after read", {7'd0, oe}, 8'h00);
        host_wr(2'b10, 8'h3C);
        check("R3 ctrl write", ctrl, 8'h3C);
        host_wr(2'b11, 8'h01);
        check("R3 mode write", mode, 8'h01);
        check("R12 bias tx idle", {7'd0, bias}, 8'h01);
    endtask

    task automatic t_tx_seq();
        logic [7:0] d;
        host_wr(2'b01, 8'h00);
        for (int i = 0; i < 5; i++) host_wr(2'b00, 8'hA0 + 8'(i));
        for (int i = 0; i < 5; i++) begin
            peek(i, d);
            check("R4 tx sequence", d, 8'hA0 + 8'(i));
        end
    endtask

    task automatic t_saturate();
        logic [7:0] d;
        host_wr(2'b01, 8'h00);
        for (int i = 0; i < 20; i++) host_wr(2'b00, 8'h10 + 8'(i));
        peek(16, d); check("R5 loc16", d, 8'h20);
        peek(17, d); check("R5 loc17 saturated", d, 8'h23);
    endtask

    task automatic t_cmd_rewind();
        logic [7:0] d;
        host_wr(2'b01, 8'h00);
        host_wr(2'b00, 8'h77);
        peek(0, d); check("R6 rewind loc0", d, 8'h77);
        peek(1, d); check("R6 loc1 kept", d, 8'h11);
    endtask

    task automatic t_direction();
        logic [7:0] d; logic e;
        host_wr(2'b11, 8'h00);
        host_wr(2'b01, 8'h00);
        host_wr(2'b00, 8'h99);
        peek(0, d); check("R8 rx write rejected", d, 8'h77);
        host_wr(2'b11, 8'h04);
        host_wr(2'b00, 8'h66);
        peek(0, d); check("R8 sync write in rx", d, 8'h66);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            dp_we = 1'b1; dp_addr = 5'(i); dp_wdata = 8'hC0 + 8'(i);
        end
        @(negedge clk); dp_we = 1'b0;
        host_wr(2'b11, 8'h00);
        host_wr(2'b01, 8'h00);
        for (int i = 0; i < 3; i++) begin
            host_rd(2'b00, d, e);
            check("R4 R8 rx read sequence", d, 8'hC0 + 8'(i));
        end
        host_wr(2'b11, 8'h01);
        host_wr(2'b01, 8'h00);
        host_rd(2'b00, d, e);
        check("R8 tx read returns zero", d, 8'h00);
        host_wr(2'b00, 8'h55);
        peek(0, d); check("R8 ptr held after rejected read", d, 8'h55);
    endtask

    task automatic t_bfree();
        logic [7:0] d; logic e;
        int nt;
        nt = n_task;
        host_wr(2'b01, 8'h03);
        check("R9 task pulse count", 8'(n_task - nt), 8'h01);
        check("R9 task code", {5'd0, last_task}, 8'h03);
        check("R12 busy not idle", {7'd0, idle}, 8'h00);
        host_rd(2'b01, d, e);
        check("R11 bfree cleared", d, 8'h15);
        host_wr(2'b00, 8'hEE);
        peek(0, d); check("R7 write blocked", d, 8'h55);
        host_wr(2'b11, 8'h00);
        host_rd(2'b00, d, e);
        check("R7 read blocked", d, 8'h00);
        @(negedge clk); buf_free = 1'b1;
        @(negedge clk); buf_free = 1'b0;
        host_rd(2'b01, d, e);
        check("R11 bfree set", d, 8'h95);
        check("R12 still busy", {7'd0, idle}, 8'h00);
        @(negedge clk); task_done = 1'b1;
        @(negedge clk); task_done = 1'b0;
        check("R12 idle after done", {7'd0, idle}, 8'h01);
        host_wr(2'b11, 8'h03);
        check("R12 psave not idle", {7'd0, idle}, 8'h00);
        check("R12 psave no bias", {7'd0, bias}, 8'h00);
    endtask

    task automatic t_command();
        logic [7:0] d;
        int na, nt;
        host_wr(2'b11, 8'h00);
        na = n_aqbc;
        host_wr(2'b01, 8'hC2);
        check("R10 aqbc rx", 8'(n_aqbc - na), 8'h01);
        check("R9 task code 2", {5'd0, last_task}, 8'h02);
        check("R10 aqlev set", {7'd0, aqlev}, 8'h01);
        release_buf();
        na = n_aqbc;
        host_wr(2'b01, 8'h87);
        check("R10 no aqbc on reset task", 8'(n_aqbc - na), 8'h00);
        check("R9 task code 7", {5'd0, last_task}, 8'h07);
        release_buf();
        host_wr(2'b01, 8'h05);
        check("R10 aqlev cleared", {7'd0, aqlev}, 8'h00);
        release_buf();
        host_wr(2'b11, 8'h01);
        na = n_aqbc;
        host_wr(2'b01, 8'h80);
        check("R10 no aqbc in tx", 8'(n_aqbc - na), 8'h00);
        host_wr(2'b01, 8'h00);
        host_wr(2'b00, 8'h01);
        nt = n_task;
        host_wr(2'b01, 8'h68);
        check("R9 reserved no pulse", 8'(n_task - nt), 8'h00);
        check("R9 reserved no level", {7'd0, aqlev}, 8'h00);
        host_wr(2'b00, 8'h02);
        peek(0, d); check("R9 loc0", d, 8'h01);
        peek(1, d); check("R9 reserved no rewind", d, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_tx_seq();
        t_saturate();
        t_cmd_rewind();
        t_direction();
        t_bfree();
        t_command();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule